// File: doc/BRIEF.md
# Dual-Port Memory Collision Detector

This block sits beside a dual-port synchronous memory. It watches the access that each of the two ports makes in every cycle. When both ports touch the same word in a way that can corrupt stored data or return unreliable read data, it drives an active-low collision flag. The flag goes only to the port whose data is at risk. A port is flagged whenever the other port writes the shared word. Two reads of the same word flag nothing. Two writes flag both ports.

Each port has a pair of chip selects, a read/write select and an address. All of them are captured on the clock edge. The address is the memory's internal registered address, such as a counter output, and not the raw pin bus. The two port clocks are assumed to come from a common reference, so the block runs on a single clock `clk`.

The flag on the trailing port always appears two cycles after the capture edge. The flag on the leading port appears two cycles after it for a small clock offset (region 1) or three cycles after it for a larger offset (region 2). Parameters select the region and which port leads. The flag is re-evaluated every cycle, so it goes high again, with the same latency, once the conflicting pair of accesses ends.

Top module: `colDetector`

## Requirements
- R1: A port takes part in collision checking only in a cycle where its low-active select (`*SelLoN`) is 0 and its high-active select (`*SelHi`) is 1, both captured on the clock edge. If either port is not selected, neither flag asserts for that cycle.
- R2: A collision needs both captured addresses to be equal. Any difference in any address bit means no flag.
- R3: When both selected ports read the same word (`*WriteN` = 1 on both), neither flag asserts.
- R4: When the left port reads and the right port writes the same word, only `leftColN` asserts.
- R5: When the right port reads and the left port writes the same word, only `rightColN` asserts.
- R6: When both selected ports write the same word (`*WriteN` = 0 on both), both flags assert.
- R7: Both flags are active low (0 means collision) and are 1 while `rstN` is low and after it is released.
- R8: The trailing port's flag reflects the access pair captured on edge n from just after edge n+2.
- R9: The leading port's flag reflects the access pair captured on edge n from just after edge n+2 when `REGION` = 1, and from just after edge n+3 when `REGION` = 2. `LEAD_RIGHT` = 0 makes the left port lead; 1 makes the right port lead.
- R10: Each flag is evaluated per captured cycle. A flag that was asserted returns to 1 with the same latency once the captured pair no longer qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset |
| leftSelLoN | input | 1 | Left port select, active low |
| leftSelHi | input | 1 | Left port select, active high |
| leftWriteN | input | 1 | Left port direction: 1 read, 0 write |
| leftAddr | input | ADDR_W | Left port internal address |
| rightSelLoN | input | 1 | Right port select, active low |
| rightSelHi | input | 1 | Right port select, active high |
| rightWriteN | input | 1 | Right port direction: 1 read, 0 write |
| rightAddr | input | ADDR_W | Right port internal address |
| leftColN | output | 1 | Left port collision flag, active low |
| rightColN | output | 1 | Right port collision flag, active low |

## Verification
The assertions check three things on every cycle after reset. The first is that the classifier never flags a pair of reads and never flags a cycle with an unselected port. The second is that it flags both ports for every matching pair of writes. The third is that each output equals its classifier strobe delayed by exactly that port's configured latency. Only the bench's scenarios can show the end-to-end results, because they compare against a model built from the port-level requirements. These results are the per-direction flag selection for every select, direction and address combination of a 3-bit address, the distinct latencies of leading and trailing ports in both regions, and flag release as the pattern changes cycle by cycle.

// File: rtl/colDetPkg.sv
package colDetPkg;

  // Captured access pair, handed from the capture datapath to the classifier.
  typedef struct packed {
    logic leftEn;
    logic leftWr;
    logic rightEn;
    logic rightWr;
    logic addrEq;
  } accSnap_t;

  // Per-port hit strobes, handed from the classifier to the flag delay lines.
  typedef struct packed {
    logic hitLeft;
    logic hitRight;
  } colStrobe_t;

endpackage

// File: rtl/colCapture.sv
module colCapture #(
  parameter int ADDR_W = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                leftSelLoN,
  input  logic                leftSelHi,
  input  logic                leftWriteN,
  input  logic [ADDR_W-1:0]   leftAddr,
  input  logic                rightSelLoN,
  input  logic                rightSelHi,
  input  logic                rightWriteN,
  input  logic [ADDR_W-1:0]   rightAddr,
  output colDetPkg::accSnap_t snap
);

  logic              leftEnQ, leftWrQ, rightEnQ, rightWrQ;
  logic [ADDR_W-1:0] leftAddrQ, rightAddrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftEnQ    <= 1'b0;
      leftWrQ    <= 1'b0;
      leftAddrQ  <= '0;
      rightEnQ   <= 1'b0;
      rightWrQ   <= 1'b0;
      rightAddrQ <= '0;
    end else begin
      leftEnQ    <= !leftSelLoN && leftSelHi;
      leftWrQ    <= !leftWriteN;
      leftAddrQ  <= leftAddr;
      rightEnQ   <= !rightSelLoN && rightSelHi;
      rightWrQ   <= !rightWriteN;
      rightAddrQ <= rightAddr;
    end
  end

  always_comb begin
    snap.leftEn  = leftEnQ;
    snap.leftWr  = leftWrQ;
    snap.rightEn = rightEnQ;
    snap.rightWr = rightWrQ;
    snap.addrEq  = (leftAddrQ == rightAddrQ);
  end

endmodule

// File: rtl/colClassify.sv
module colClassify (
  input  colDetPkg::accSnap_t   snap,
  output colDetPkg::colStrobe_t strb
);

  logic sameWord;

  always_comb begin
    sameWord      = snap.leftEn && snap.rightEn && snap.addrEq;
    // A port is endangered whenever the opposite port writes the shared word.
    strb.hitLeft  = sameWord && snap.rightWr;
    strb.hitRight = sameWord && snap.leftWr;
  end

endmodule

// File: rtl/colDelay.sv
module colDelay #(
  parameter int LEFT_DLY  = 2,
  parameter int RIGHT_DLY = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  colDetPkg::colStrobe_t strb,
  output logic                  leftColN,
  output logic                  rightColN
);

  logic [1:0] hitVec;
  logic [1:0] flagN;

  assign hitVec    = {strb.hitRight, strb.hitLeft};
  assign leftColN  = flagN[0];
  assign rightColN = flagN[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int DEPTH = (p == 0) ? LEFT_DLY : RIGHT_DLY;
    logic [DEPTH-1:0] pipe;

    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= hitVec[p];
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[DEPTH-2:0], hitVec[p]};
      end
    end

    assign flagN[p] = ~pipe[DEPTH-1];
  end

endmodule

// File: rtl/colDetector.sv
module colDetector #(
  parameter int ADDR_W     = 18,
  parameter int REGION     = 1,
  parameter bit LEAD_RIGHT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              leftSelLoN,
  input  logic              leftSelHi,
  input  logic              leftWriteN,
  input  logic [ADDR_W-1:0] leftAddr,
  input  logic              rightSelLoN,
  input  logic              rightSelHi,
  input  logic              rightWriteN,
  input  logic [ADDR_W-1:0] rightAddr,
  output logic              leftColN,
  output logic              rightColN
);

  // Latencies count edges after the capture edge; capture itself adds the first.
  localparam int LEAD_LAT  = (REGION == 2) ? 3 : 2;
  localparam int TRAIL_LAT = 2;
  localparam int LEFT_DLY  = (LEAD_RIGHT ? TRAIL_LAT : LEAD_LAT);
  localparam int RIGHT_DLY = (LEAD_RIGHT ? LEAD_LAT : TRAIL_LAT);

  colDetPkg::accSnap_t   snap;
  colDetPkg::colStrobe_t strb;

  colCapture #(.ADDR_W(ADDR_W)) u_capture (
    .clk        (clk),
    .rstN       (rstN),
    .leftSelLoN (leftSelLoN),
    .leftSelHi  (leftSelHi),
    .leftWriteN (leftWriteN),
    .leftAddr   (leftAddr),
    .rightSelLoN(rightSelLoN),
    .rightSelHi (rightSelHi),
    .rightWriteN(rightWriteN),
    .rightAddr  (rightAddr),
    .snap       (snap)
  );

  colClassify u_classify (
    .snap(snap),
    .strb(strb)
  );

  colDelay #(.LEFT_DLY(LEFT_DLY), .RIGHT_DLY(RIGHT_DLY)) u_delay (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .leftColN (leftColN),
    .rightColN(rightColN)
  );

endmodule

// File: rtl/colDetectorChk.sv
module colDetectorChk #(
  parameter int LEFT_DLY  = 2,
  parameter int RIGHT_DLY = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input colDetPkg::accSnap_t   snap,
  input colDetPkg::colStrobe_t strb,
  input logic                  leftColN,
  input logic                  rightColN
);

  logic [2:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  AST_READ_READ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (snap.leftEn && snap.rightEn && !snap.leftWr && !snap.rightWr) |-> (!strb.hitLeft && !strb.hitRight)); // R3

  AST_WRITE_WRITE_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (snap.leftEn && snap.rightEn && snap.addrEq && snap.leftWr && snap.rightWr) |-> (strb.hitLeft && strb.hitRight)); // R6

  AST_IDLE_PORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!snap.leftEn || !snap.rightEn) |-> (!strb.hitLeft && !strb.hitRight)); // R1

  AST_LEFT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sinceRst) > LEFT_DLY) |-> (leftColN == !$past(strb.hitLeft, LEFT_DLY))); // R9

  AST_RIGHT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (int'(sinceRst) > RIGHT_DLY) |-> (rightColN == !$past(strb.hitRight, RIGHT_DLY))); // R8

endmodule

bind colDetector colDetectorChk #(.LEFT_DLY(LEFT_DLY), .RIGHT_DLY(RIGHT_DLY)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .snap     (snap),
  .strb     (strb),
  .leftColN (leftColN),
  .rightColN(rightColN)
);

// File: tb/colDetector_test.sv
module colDetector_test;

  localparam int AW    = 3;
  localparam int NVEC  = 4096;
  localparam int TAILS = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lLo, lHi, lWn, rLo, rHi, rWn;
  logic [AW-1:0] lAd, rAd;
  logic          uLeftN, uRightN, vLeftN, vRightN;

  int checks = 0;
  int fails  = 0;
  logic [11:0] hist [NVEC];

  always #2 clk = ~clk;

  // Region 2, left leads: left latency 3, right latency 2.
  colDetector #(.ADDR_W(AW), .REGION(2), .LEAD_RIGHT(1'b0)) uut (
    .clk(clk), .rstN(rstN),
    .leftSelLoN(lLo), .leftSelHi(lHi), .leftWriteN(lWn), .leftAddr(lAd),
    .rightSelLoN(rLo), .rightSelHi(rHi), .rightWriteN(rWn), .rightAddr(rAd),
    .leftColN(uLeftN), .rightColN(uRightN));

  // Region 1, right leads: both latencies 2.
  colDetector #(.ADDR_W(AW), .REGION(1), .LEAD_RIGHT(1'b1)) uut2 (
    .clk(clk), .rstN(rstN),
    .leftSelLoN(lLo), .leftSelHi(lHi), .leftWriteN(lWn), .leftAddr(lAd),
    .rightSelLoN(rLo), .rightSelHi(rHi), .rightWriteN(rWn), .rightAddr(rAd),
    .leftColN(vLeftN), .rightColN(vRightN));

  // Vector layout: [11] lLo [10] lHi [9] lWn [8:6] lAd [5] rLo [4] rHi [3] rWn [2:0] rAd
  localparam logic [11:0] IDLE = 12'b100_000_100_000;

  function automatic logic [11:0] vecAt(int idx);
    if (idx < 0 || idx >= NVEC) return IDLE;
    return hist[idx];
  endfunction

  // Expected active-low flag for one port: side 0 = left, 1 = right.
  function automatic logic expFlagN(logic [11:0] v, int side);
    logic both;
    both = !v[11] && v[10] && !v[5] && v[4] && (v[8:6] == v[2:0]);
    if (side == 0) return !(both && !v[3]);
    return !(both && !v[9]);
  endfunction

  function automatic string tagOf(logic [11:0] v);
    if (v[11] || !v[10] || v[5] || !v[4]) return "R1";
    if (v[8:6] != v[2:0])                 return "R2";
    case ({v[9], v[3]})
      2'b11:   return "R3";
      2'b10:   return "R4";
      2'b01:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic checkOne(string what, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s R10: actual %b expected %b at %0t", what, tag, act, exp, $time);
    end
  endtask

  task automatic drive(logic [11:0] v);
    {lLo, lHi, lWn, lAd, rLo, rHi, rWn, rAd} = v;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NVEC; i++) hist[i] = 12'((i * 1237) % NVEC);
    drive(IDLE);
    repeat (3) @(negedge clk);
    // R7: flags high during reset
    checkOne("reset uut.left",  "R7", uLeftN,  1'b1);
    checkOne("reset uut.right", "R7", uRightN, 1'b1);
    checkOne("reset uut2.left", "R7", vLeftN,  1'b1);
    checkOne("reset uut2.right","R7", vRightN, 1'b1);
    rstN = 1'b1;
    for (int m = 0; m < NVEC + TAILS; m++) begin
      if (m > 0) @(negedge clk);
      // After edge m-1, a port with latency D shows vector m-1-D.
      checkOne("uut.left lead R9",   tagOf(vecAt(m - 4)), uLeftN,  expFlagN(vecAt(m - 4), 0));
      checkOne("uut.right trail R8", tagOf(vecAt(m - 3)), uRightN, expFlagN(vecAt(m - 3), 1));
      checkOne("uut2.left trail R8", tagOf(vecAt(m - 3)), vLeftN,  expFlagN(vecAt(m - 3), 0));
      checkOne("uut2.right lead R9", tagOf(vecAt(m - 3)), vRightN, expFlagN(vecAt(m - 3), 1));
      drive(vecAt(m));
    end
    // R7: flags high after idle tail
    checkOne("idle uut.left",  "R7", uLeftN,  1'b1);
    checkOne("idle uut.right", "R7", uRightN, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule